// File: doc/BRIEF.md
# Write Precompensation Shifter

This block sits between a serial flux-transition encoder and the drive's write-data line. Every transition pulse is sent on after a programmable delay, measured in ticks. A tick is a one-clock strobe that runs at twice the 8 MHz master rate, so one tick is 62.5 ns. The block uses the same 8 MHz timing base in both recording densities.

In double-density (MFM) mode, with compensation enabled, each transition is moved about 187.5 ns (three ticks) away from the nominal instant. The direction depends on the cells on either side of it, and the move counters the peak shift that adjacent transitions cause on inner tracks. Single-density (FM) streams are never moved, and neither are commands that do not ask for compensation. Those transitions keep the nominal three-tick delay, so all output timing stays on one grid.

The density and the compensation control bit of the write command are captured when the command is loaded. They stay fixed until the next load.

Top module: `wprecomp`

## Requirements
- R1: After reset, `wd_out` is low. Compensation is off until the first `cmd_load`, so pulses get the nominal delay.
- R2: Compensation is active only when the last load captured `dens_mfm`=1 and `cmd_b1`=0. With `cmd_b1`=1 every pulse gets the nominal delay.
- R3: With compensation active, a pulse whose context `nbr` = {previous, current, next} cell = 3'b011 is written early. Its output starts at the tick edge that captures it (delay 0).
- R4: With compensation active, a pulse with `nbr` = 3'b110 is written late. Its output starts 6 tick edges after the capturing edge.
- R5: With compensation active, every other `nbr` pattern gives the nominal delay of 3 tick edges.
- R6: When the last load captured `dens_mfm`=0 (FM), every pulse gets the nominal 3-tick delay, whatever `cmd_b1` and `nbr` are.
- R7: Changes on `dens_mfm` and `cmd_b1` have no effect unless `cmd_load` is high.
- R8: A pulse captured on the same clock edge as `cmd_load` uses the settings that were held before that load.
- R9: Each output pulse stays high for exactly 2 ticks (one 8 MHz period), whatever its shift. `wd_out` changes only after edges where `tick` is high.
- R10: `flux_in` is sampled only on clock edges where `tick` is high. If it is high only on other edges, it produces no output.
- R11: Two pulses whose shifted start times land on the same tick give a single 2-tick output pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at 16 MHz (half of an 8 MHz period) |
| cmd_load | input | 1 | Captures `dens_mfm` and `cmd_b1` at the start of a write command |
| dens_mfm | input | 1 | Density select: 1 = MFM, 0 = FM |
| cmd_b1 | input | 1 | Bit 1 of the write command; 0 enables compensation |
| flux_in | input | 1 | Transition pulse, sampled on tick edges |
| nbr | input | 3 | Cell context {previous, current, next} for the pulse |
| wd_out | output | 1 | Shifted write-data pulse |

## Verification
Two things can fall in the same cycle, and the bench provokes both on purpose. First, a command load can coincide with a captured pulse. The bench loads a compensating setup in the very cycle that an early-pattern pulse is presented, then checks that the pulse starts at the nominal three-tick delay and that the next early pulse starts at once. Second, a late-shifted pulse and an early-shifted pulse can start together. The bench sends the early pulse exactly six ticks after the late one, expects a single rising edge at the shared tick, and measures that pulse's width as two ticks.

// File: rtl/wprecomp.sv
module wprecomp #(
  parameter int SHIFT_TICKS = 3,
  parameter int WIDTH_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_load,
  input  logic       dens_mfm,
  input  logic       cmd_b1,
  input  logic       flux_in,
  input  logic [2:0] nbr,
  output logic       wd_out
);
  localparam int SL = 2 * SHIFT_TICKS + 1;
  localparam int HL = WIDTH_TICKS - 1;

  logic          mfm_q, nopc_q;
  logic [SL-1:0] sched, slot;
  logic [HL-1:0] hold;

  wire comp_on = mfm_q & ~nopc_q;
  wire early   = comp_on & (nbr == 3'b011);
  wire late    = comp_on & (nbr == 3'b110);

  always_comb begin
    slot = '0;
    if (early)     slot[0]           = 1'b1;
    else if (late) slot[SL-1]        = 1'b1;
    else           slot[SHIFT_TICKS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mfm_q  <= 1'b0;
      nopc_q <= 1'b1;
      sched  <= '0;
      hold   <= '0;
    end else begin
      if (cmd_load) begin
        mfm_q  <= dens_mfm;
        nopc_q <= cmd_b1;
      end
      if (tick) begin
        sched <= (sched >> 1) | (flux_in ? slot : '0);
        hold  <= HL'({hold, sched[0]});
      end
    end
  end

  assign wd_out = sched[0] | (|hold);
endmodule

module wprecomp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cmd_load,
  input logic       flux_in,
  input logic [2:0] nbr,
  input logic       mfm_q,
  input logic       nopc_q,
  input logic       wd_out
);
  AST_RESET_LOW: assert property (@(posedge clk) $rose(rst_n) |-> !wd_out); // R1
  AST_EARLY_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && flux_in && mfm_q && !nopc_q && nbr == 3'b011) |=> wd_out); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_load |=> ($stable(mfm_q) && $stable(nopc_q))); // R7
  AST_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_out) |=> wd_out); // R9
  AST_TICK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_out != $past(wd_out)) |-> $past(tick)); // R9
endmodule

bind wprecomp wprecomp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_load(cmd_load),
  .flux_in(flux_in), .nbr(nbr), .mfm_q(mfm_q), .nopc_q(nopc_q),
  .wd_out(wd_out)
);

// File: tb/wprecomp_tb.sv
module wprecomp_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cmd_load = 1'b0, dens_mfm = 1'b0, cmd_b1 = 1'b1, flux_in = 1'b0;
  logic [2:0] nbr = 3'b000;
  logic wd_out;

  int checks = 0, fails = 0, tc = 0, rise_tc = 0, rises = 0, cyc = 0;
  int    exp_q[$];
  string tag_q[$];
  string cur_tag = "";
  logic  prev_out = 1'b0;
  bit    done = 1'b0;

  wprecomp u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .cmd_load(cmd_load),
    .dens_mfm(dens_mfm), .cmd_b1(cmd_b1), .flux_in(flux_in), .nbr(nbr), .wd_out(wd_out));

  always #4 clk = ~clk;
  always @(negedge clk) tick <= ~tick;
  always @(posedge clk) if (tick) tc <= tc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wd_out && !prev_out) begin
        rises++;
        rise_tc = tc;
        if (exp_q.size() == 0) check(1'b0, "R10/R11 unexpected rise", tc, -1);
        else begin
          cur_tag = tag_q.pop_front();
          check(exp_q.pop_front() == tc, cur_tag, tc, exp_q.size() >= 0 ? tc : 0);
        end
      end
      if (!wd_out && prev_out) check(tc - rise_tc == 2, "R9 width", tc - rise_tc, 2);
    end
    prev_out = wd_out;
  end

  task automatic load(input logic m, input logic b);
    @(negedge clk);
    dens_mfm = m; cmd_b1 = b; cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0;
  endtask

  task automatic send(input logic [2:0] n, input int d, input string req, input bit push, input bit co);
    int e;
    @(posedge clk iff tick);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    flux_in = 1'b1; nbr = n;
    if (co) cmd_load = 1'b1;
    e = tc + 1 + d;
    if (push) begin exp_q.push_back(e); tag_q.push_back(req); end
    @(posedge clk);
    @(negedge clk);
    flux_in = 1'b0; cmd_load = 1'b0; nbr = 3'b000;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk iff tick);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(wd_out == 1'b0, "R1 reset output", wd_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wd_out == 1'b0, "R1 after release", wd_out, 0);
    send(3'b011, 3, "R1 default nominal", 1, 0); idle(12);

    load(1'b1, 1'b0);
    send(3'b011, 0, "R3 early", 1, 0); idle(12);
    send(3'b110, 6, "R4 late", 1, 0); idle(12);
    send(3'b010, 3, "R5 pattern 010", 1, 0); idle(12);
    send(3'b111, 3, "R5 pattern 111", 1, 0); idle(12);
    send(3'b001, 3, "R5 pattern 001", 1, 0); idle(12);

    load(1'b1, 1'b1);
    send(3'b011, 3, "R2 disabled early pattern", 1, 0); idle(12);
    send(3'b110, 3, "R2 disabled late pattern", 1, 0); idle(12);

    load(1'b0, 1'b0);
    send(3'b011, 3, "R6 FM early pattern", 1, 0); idle(12);
    send(3'b110, 3, "R6 FM late pattern", 1, 0); idle(12);

    load(1'b1, 1'b1);
    @(negedge clk); dens_mfm = 1'b1; cmd_b1 = 1'b0;
    send(3'b011, 3, "R7 pins changed without load", 1, 0); idle(12);

    send(3'b011, 3, "R8 load in same cycle uses old", 1, 1); idle(12);
    send(3'b011, 0, "R8 new settings after load", 1, 0); idle(12);

    begin
      int r0;
      r0 = rises;
      @(posedge clk iff tick);
      @(negedge clk);
      flux_in = 1'b1; nbr = 3'b011;
      @(negedge clk);
      flux_in = 1'b0; nbr = 3'b000;
      idle(12);
      check(rises == r0, "R10 off-tick pulse ignored", rises - r0, 0);
    end

    send(3'b110, 6, "R11 merged late+early", 1, 0);
    idle(4);
    send(3'b011, 0, "R11 merged", 0, 0);
    idle(12);

    check(exp_q.size() == 0, "R11 all expected pulses seen", exp_q.size(), 0);
    check(wd_out == 1'b0, "R9 idle output", wd_out, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual %0d expected <20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule